// File: doc/BRIEF.md
# Burst SRAM Address and Write Front End

This block is the synchronous front end of a small burst SRAM that holds its words in an internal register array. On every rising clock edge it samples an external address, a chip enable, two burst-start strobes, a burst-step strobe, per-byte write selects, a byte-write enable and a global write. It produces the word address and a per-byte write mask for the array. Read data comes straight out of the array at the current address.

A burst starts when either start strobe loads a new base address. The lowest two address bits then form a four-beat burst counter. The counter moves forward only on cycles where the step strobe is high. A mode input selects the beat order. With the mode input at 1 the order is linear: base plus beat count, modulo 4. With the mode input at 0 the order is interleaved: base XOR beat count. Interleaved is the default when the mode input is tied low. Bursting is optional, because a fresh address can be loaded on every cycle.

The write controls for the access are merged into one mask and registered. The array applies that mask at the following edge.

Top module: `burst_sram_front`

## Requirements
- R1: After synchronous reset, `addr_out` is 0, `wmask_out` is 0 and the block is deselected.
- R2: `start_c` always loads `addr_in` as the burst base. `start_p` loads it only when `chip_en` is 1 and is ignored otherwise. The loaded address appears on `addr_out` right after the loading edge.
- R3: When `start_p` and `chip_en` are both high, the cycle is a primary-started read. The write controls are ignored and `wmask_out` is 0, even if `start_c` is also high. A `start_c`-only start does accept writes.
- R4: With no load, `addr_out` advances one beat after an edge where `step_en` is 1. It holds when `step_en` is 0.
- R5: With `lin_order`=1, the low two bits follow (base + n) mod 4 for beat n.
- R6: With `lin_order`=0, the low two bits follow base XOR n.
- R7: A fourth step returns the low bits to the base. Bits above bit 1 never change during a burst.
- R8: With `byte_wr`=1 and `glob_wr`=0, `wmask_out` equals `byte_sel`. Mask bit i covers data bits 8i+7..8i, and only those bytes of the word change.
- R9: With `glob_wr`=1 on a selected write cycle, `wmask_out` is all ones and the whole word is written, whatever `byte_wr` and `byte_sel` are.
- R10: `start_c` with `chip_en`=0 deselects the block until the next load with `chip_en`=1. While deselected, or with no byte selected and `glob_wr`=0, the mask is 0 and memory is unchanged.
- R11: A different address can be loaded on every consecutive cycle with no idle cycles, and each access takes effect.
- R12: The mask registered at edge k is written into the array at edge k+1. `rdata` shows the array word at `addr_out` without a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, sampled on a burst start |
| start_p | input | 1 | Primary burst-start strobe (read start, gated by chip_en) |
| start_c | input | 1 | Controller burst-start strobe (always honoured) |
| step_en | input | 1 | Advance the burst counter one beat |
| addr_in | input | AW | External word address |
| byte_sel | input | NB | Per-byte write selects |
| byte_wr | input | 1 | Byte-write enable |
| glob_wr | input | 1 | Global write, all bytes |
| wdata | input | 8*NB | Write data |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr_out | output | AW | Current array word address |
| wmask_out | output | NB | Registered per-byte write mask |
| rdata | output | 8*NB | Array word at addr_out |

## Verification
The embedded properties assume that `lin_order` stays steady for the whole of a burst. If it changed partway through, the current address would be recomputed in the new order and the hold property would see a jump. The stimulus changes the order only on a cycle that also loads a new base. The properties also take the write controls to be known values on every cycle. The bench drives every input at each falling edge and returns unused controls to 0 between scenarios, so nothing floats.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } burst_order_e;

    // Per-cycle decoded access control
    typedef struct packed {
        logic load;        // a base address is taken this cycle
        logic read_start;  // primary-started cycle: writes suppressed
        logic sel_next;    // selection state in effect for this access
    } access_ctl_t;

    function automatic logic [1:0] beat_offset(
        input logic [1:0]   base,
        input logic [1:0]   beat,
        input burst_order_e ord
    );
        logic [1:0] sum;
        sum = base + beat;
        return (ord == ORD_LINEAR) ? sum : (base ^ beat);
    endfunction

endpackage

// File: rtl/bsf_burst_ctr.sv
module bsf_burst_ctr
    import bsf_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    input  burst_order_e  ord,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);
    localparam int HI_W = AW - 2;

    logic [HI_W-1:0] hi_q;
    logic [1:0]      base_q;
    logic [1:0]      beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            base_q <= '0;
            beat_q <= '0;
        end else if (load) begin
            hi_q   <= addr_in[AW-1:2];
            base_q <= addr_in[1:0];
            beat_q <= '0;
        end else if (adv) begin
            beat_q <= beat_q + 2'd1;
        end
    end

    assign addr_out = {hi_q, beat_offset(base_q, beat_q, ord)};

    a_r2_load_takes_base: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load)) |-> (addr_out == $past(addr_in)));

    a_r4_hold_without_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!load && !adv) && $stable(ord)) |-> $stable(addr_out));

    a_r7_upper_bits_kept: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv && !load)) |-> (addr_out[AW-1:2] == $past(addr_out[AW-1:2])));

endmodule

// File: rtl/bsf_wmask.sv
module bsf_wmask #(
    parameter int NB = 4
) (
    input  logic          enable,
    input  logic          glob,
    input  logic          byte_wr,
    input  logic [NB-1:0] byte_sel,
    output logic [NB-1:0] mask
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign mask[i] = enable & (glob | (byte_wr & byte_sel[i]));
    end
endmodule

// File: rtl/bsf_array.sv
module bsf_array
    import bsf_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic                 clk,
    input  logic [AW-1:0]        addr,
    input  logic [NB-1:0]        wmask,
    input  logic [NB*BYTE_W-1:0] wdata,
    output logic [NB*BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [NB*BYTE_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < NB; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wmask[i])
                mem[addr][i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front
    import bsf_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 chip_en,
    input  logic                 start_p,
    input  logic                 start_c,
    input  logic                 step_en,
    input  logic [AW-1:0]        addr_in,
    input  logic [NB-1:0]        byte_sel,
    input  logic                 byte_wr,
    input  logic                 glob_wr,
    input  logic [NB*BYTE_W-1:0] wdata,
    input  logic                 lin_order,
    output logic [AW-1:0]        addr_out,
    output logic [NB-1:0]        wmask_out,
    output logic [NB*BYTE_W-1:0] rdata
);
    localparam int DW = NB * BYTE_W;

    access_ctl_t          ctl;
    logic                 sel_q;
    logic [NB-1:0]        mask_d;
    logic [NB-1:0]        wmask_q;
    logic [DW-1:0]        wdata_q;
    burst_order_e         ord;

    assign ord = burst_order_e'(lin_order);

    always_comb begin
        ctl.read_start = start_p & chip_en;
        ctl.load       = ctl.read_start | start_c;
        ctl.sel_next   = ctl.load ? chip_en : sel_q;
    end

    bsf_burst_ctr #(.AW(AW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .adv      (step_en),
        .ord      (ord),
        .addr_in  (addr_in),
        .addr_out (addr_out)
    );

    bsf_wmask #(.NB(NB)) u_mask (
        .enable   (ctl.sel_next & ~ctl.read_start),
        .glob     (glob_wr),
        .byte_wr  (byte_wr),
        .byte_sel (byte_sel),
        .mask     (mask_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            wmask_q <= '0;
            wdata_q <= '0;
        end else begin
            sel_q   <= ctl.sel_next;
            wmask_q <= mask_d;
            wdata_q <= wdata;
        end
    end

    // Registered access is committed at the following edge
    bsf_array #(.AW(AW), .NB(NB)) u_array (
        .clk   (clk),
        .addr  (addr_out),
        .wmask (wmask_q),
        .wdata (wdata_q),
        .rdata (rdata)
    );

    assign wmask_out = wmask_q;

    a_r3_primary_start_reads: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(start_p && chip_en)) |-> (wmask_out == '0));

    a_r9_global_fills_mask: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(glob_wr && start_c && chip_en && !start_p)) |-> (wmask_out == '1));

    a_r10_deselect_blocks: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(start_c && !chip_en)) |-> (wmask_out == '0));

    a_r8_mask_within_select: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!glob_wr)) |-> ((wmask_out & ~$past(byte_sel)) == '0));

endmodule

// File: tb/burst_sram_front_bench.sv
`timescale 1ns/1ps
module burst_sram_front_bench;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = NB * 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          chip_en, start_p, start_c, step_en;
    logic [AW-1:0] addr_in;
    logic [NB-1:0] byte_sel;
    logic          byte_wr, glob_wr;
    logic [DW-1:0] wdata;
    logic          lin_order;
    logic [AW-1:0] addr_out;
    logic [NB-1:0] wmask_out;
    logic [DW-1:0] rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    burst_sram_front #(.AW(AW), .NB(NB)) u_burst_sram_front (
        .clk(clk), .rst(rst), .chip_en(chip_en), .start_p(start_p),
        .start_c(start_c), .step_en(step_en), .addr_in(addr_in),
        .byte_sel(byte_sel), .byte_wr(byte_wr), .glob_wr(glob_wr),
        .wdata(wdata), .lin_order(lin_order), .addr_out(addr_out),
        .wmask_out(wmask_out), .rdata(rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        chip_en = 0; start_p = 0; start_c = 0; step_en = 0;
        addr_in = '0; byte_sel = '0; byte_wr = 0; glob_wr = 0; wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic readback(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        idle();
        chip_en = 1; start_c = 1; addr_in = a;
        tick();
        chk(req, rdata, exp);
    endtask

    task automatic gwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle();
        chip_en = 1; start_c = 1; glob_wr = 1; addr_in = a; wdata = d;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 addr", addr_out, 0);
        chk("R1 mask", wmask_out, 0);
        idle(); glob_wr = 1; step_en = 0;
        tick();
        chk("R1 deselected no write", wmask_out, 0);
    endtask

    task automatic t_load();
        idle(); start_c = 1; chip_en = 1; addr_in = 6'h15;
        tick();
        chk("R2 start_c load", addr_out, 6'h15);
        idle(); start_p = 1; chip_en = 0; addr_in = 6'h33;
        tick();
        chk("R2 start_p ignored", addr_out, 6'h15);
        idle(); start_p = 1; chip_en = 1; addr_in = 6'h2A;
        tick();
        chk("R2 start_p load", addr_out, 6'h2A);
        idle(); start_p = 1; start_c = 1; chip_en = 0; addr_in = 6'h0C;
        tick();
        chk("R2 start_c honoured without enable", addr_out, 6'h0C);
    endtask

    task automatic t_burst(input logic lin, input logic [AW-1:0] base, input string req);
        idle(); lin_order = lin; start_c = 1; chip_en = 1; addr_in = base;
        tick();
        chk(req, addr_out, base);
        for (int n = 1; n <= 4; n++) begin
            logic [1:0] lo;
            idle(); step_en = 1;
            tick();
            lo = lin ? 2'(base[1:0] + 2'(n)) : (base[1:0] ^ 2'(n));
            chk(n == 4 ? "R7 wrap to base" : req, addr_out, {base[AW-1:2], lo});
            if (n == 2) begin
                idle();
                tick();
                chk("R4 hold without step", addr_out, {base[AW-1:2], lo});
            end
        end
    endtask

    task automatic t_writes();
        gwrite(6'd5, 32'hA1B2C3D4);
        chk("R9 global mask", wmask_out, 4'hF);
        readback(6'd5, 32'hA1B2C3D4, "R12 global data");
        idle(); chip_en = 1; start_c = 1; addr_in = 6'd5;
        byte_wr = 1; byte_sel = 4'b0101; wdata = 32'h11223344;
        tick();
        chk("R8 byte mask", wmask_out, 4'b0101);
        readback(6'd5, 32'hA122C344, "R8 only selected bytes");
        idle(); chip_en = 1; start_c = 1; addr_in = 6'd5;
        byte_wr = 1; byte_sel = 4'b0011; glob_wr = 1; wdata = 32'h99887766;
        tick();
        chk("R9 global overrides selects", wmask_out, 4'hF);
        readback(6'd5, 32'h99887766, "R9 whole word");
    endtask

    task automatic t_nowrite();
        idle(); chip_en = 1; start_c = 1; addr_in = 6'd5;
        byte_wr = 1; byte_sel = 4'b0000; wdata = 32'hFFFFFFFF;
        tick();
        chk("R10 no byte selected", wmask_out, 0);
        readback(6'd5, 32'h99887766, "R10 unchanged");
        idle(); chip_en = 0; start_c = 1; addr_in = 6'd5; glob_wr = 1; wdata = 32'h0;
        tick();
        chk("R10 deselect mask", wmask_out, 0);
        idle(); glob_wr = 1; wdata = 32'h0;
        tick();
        chk("R10 stays deselected", wmask_out, 0);
        idle(); glob_wr = 1; step_en = 1; wdata = 32'h0;
        tick();
        chk("R10 deselected burst", wmask_out, 0);
        readback(6'd5, 32'h99887766, "R10 memory kept");
    endtask

    task automatic t_priority();
        gwrite(6'd9, 32'h12345678);
        idle(); chip_en = 1; start_p = 1; start_c = 1; glob_wr = 1;
        addr_in = 6'd9; wdata = 32'hDEADBEEF;
        tick();
        chk("R3 both strobes addr", addr_out, 6'd9);
        chk("R3 primary start no write", wmask_out, 0);
        readback(6'd9, 32'h12345678, "R3 memory kept");
    endtask

    task automatic t_b2b();
        logic [AW-1:0] al [4] = '{6'd20, 6'd21, 6'd40, 6'd63};
        for (int i = 0; i < 4; i++) begin
            gwrite(al[i], 32'h100 + 32'(i));
            chk("R11 back-to-back addr", addr_out, al[i]);
            chk("R11 back-to-back mask", wmask_out, 4'hF);
        end
        for (int i = 0; i < 4; i++)
            readback(al[i], 32'h100 + 32'(i), "R11 data");
    endtask

    initial begin
        rst = 1; lin_order = 0; idle();
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_load();
        t_burst(1'b1, 6'h11, "R5 linear");
        t_burst(1'b1, 6'h2E, "R5 linear");
        t_burst(1'b0, 6'h23, "R6 interleaved");
        t_burst(1'b0, 6'h39, "R6 interleaved");
        t_writes();
        t_nowrite();
        t_priority();
        t_b2b();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule